// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block lets a 16-bit host bus talk to an 8-bit NAND flash device. The host sees a small register window: a data port, a mode byte, a status byte, an interrupt flag byte and an interrupt mask byte. The mode byte drives the flash control lines: command latch, address latch, chip enable and the two media power lines. The host selects data, command or address transfer simply by writing a mode value.

A data-port access turns into strobed flash cycles. A 16-bit access makes two back-to-back byte cycles, with the first flash byte in the low half of the host word. An 8-bit access makes one byte cycle, which suits command and address bytes. Each strobe stays low for a fixed number of clocks and then high for the same number. The host is held off through a wait output until the last cycle ends. The flash ready/busy line passes through a two-stage synchronizer. Its rising edge sets a ready flag that can raise the interrupt output.

Top module: `nand_bridge`

## Requirements
- R1: After reset, chip enable is high (inactive), both strobes are high, command and address latch are low, the power lines are 0, host_wait and host_irq are 0, and the mode byte reads back 0x00.
- R2: The mode byte sits at offset 4 and reads back as written. Bit 0 drives nand_cle, bit 1 drives nand_ale, bits 3:2 drive nand_pwr, and bit 4 set drives nand_ce_n low. Value 0x94 selects data transfer, 0x95 command transfer and 0x96 address transfer. Value 0x00 is standby, with nand_ce_n high.
- R3: A 16-bit read of the data port (offset 0) makes two nand_re_n cycles. The first flash byte lands in host_rdata[7:0] and the second in host_rdata[15:8].
- R4: A 16-bit write to the data port makes two nand_we_n cycles. host_wdata[7:0] goes out first, then host_wdata[15:8]. nand_doe is high whenever nand_we_n is low.
- R5: An 8-bit access to the data port makes exactly one flash cycle. An 8-bit read returns the byte in host_rdata[7:0] with zeros in bits 15:8.
- R6: Each strobe stays low for PULSE_CLKS clocks and then high for PULSE_CLKS clocks. Only one strobe is low at a time. host_wait is high for exactly 2*PULSE_CLKS clocks per byte cycle, starting the cycle after the request.
- R7: A data-port write while mode bit 7 is 0 is ignored: it makes no nand_we_n pulse and does not raise host_wait.
- R8: Status bit 7 (offset 5) reads 1 while the synchronized nand_rb is low (busy) and 0 when it is high.
- R9: A rising edge of nand_rb sets interrupt status bit 0 (offset 6), once per edge. Writing 1s to offset 6 clears those bits, and writing 0x0F clears all four.
- R10: host_irq is the OR of the interrupt status bits ANDed with the low mask bits (offset 7). Mask 0x81 enables the ready interrupt and mask 0x00 blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | One-cycle access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| host_addr | input | ADDR_W | Register offset |
| host_wdata | input | 16 | Write data (registers use bits 7:0) |
| host_rdata | output | 16 | Read data, held until the next read |
| host_wait | output | 1 | High while flash cycles are in progress |
| host_irq | output | 1 | Interrupt request |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_pwr | output | 2 | Media power control lines |
| nand_dout | output | 8 | Byte driven to the flash |
| nand_doe | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Byte from the flash |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
The assertions assume the host issues a new request only while host_wait is low. They also assume nand_rb changes slowly compared with the clock, so each clean rising edge survives the synchronizer as one pulse. The bench sends every access through one task that waits for host_wait to drop before it returns. It moves nand_rb only on falling clock edges and holds each level for several clocks. The flash model in the bench returns a known byte sequence, advancing one byte on each rising edge of the read strobe. Read data is checked against that sequence.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

    localparam int OFS_DATA = 0;
    localparam int OFS_MODE = 4;
    localparam int OFS_STAT = 5;
    localparam int OFS_FLAG = 6;
    localparam int OFS_MASK = 7;

    localparam int MB_CLE = 0;
    localparam int MB_ALE = 1;
    localparam int MB_PWR = 2;
    localparam int MB_CE  = 4;
    localparam int MB_WEQ = 7;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_t;

    typedef struct packed {
        logic        wr;
        logic        wide;
        logic [15:0] wdata;
    } xfer_t;

    typedef struct packed {
        logic       cle;
        logic       ale;
        logic       ce_n;
        logic [1:0] pwr;
    } pins_t;

    function automatic pins_t decode_mode(input logic [7:0] m);
        pins_t p;
        p.cle  = m[MB_CLE];
        p.ale  = m[MB_ALE];
        p.ce_n = ~m[MB_CE];
        p.pwr  = m[MB_PWR +: 2];
        return p;
    endfunction

    function automatic logic [7:0] lane_of(input logic [15:0] w, input logic hi);
        return hi ? w[15:8] : w[7:0];
    endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync (
    input  logic clk,
    input  logic rst,
    input  logic rb_async,
    output logic ready,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rb_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign ready = sync_q;
    assign rise  = sync_q & ~prev_q;

    AST_RISE_ONCE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R9

endmodule

// File: rtl/nand_regs.sv
module nand_regs
    import nand_bridge_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int IRQ_SRC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              rise,
    input  logic              ready,
    output logic [7:0]        mode,
    output logic              irq,
    output logic [7:0]        rd_val
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

    logic [IRQ_SRC-1:0] flag_q;
    logic [7:0]         mask_q;
    logic [IRQ_SRC-1:0] clr_bits;
    logic [IRQ_SRC-1:0] set_bits;

    always_comb begin
        clr_bits = (wr_en && addr == A_FLAG) ? wdata[IRQ_SRC-1:0] : '0;
        set_bits = '0;
        set_bits[0] = rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= '0;
            flag_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_en && addr == A_MODE) mode <= wdata;
            if (wr_en && addr == A_MASK) mask_q <= wdata;
            flag_q <= (flag_q & ~clr_bits) | set_bits;
        end
    end

    assign irq = |(flag_q & mask_q[IRQ_SRC-1:0]);

    always_comb begin
        case (addr)
            A_MODE:  rd_val = mode;
            A_STAT:  rd_val = {~ready, 7'b0};
            A_FLAG:  rd_val = 8'(flag_q);
            A_MASK:  rd_val = mask_q;
            default: rd_val = 8'h00;
        endcase
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        rise |=> flag_q[0]); // R9
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_FLAG && wdata[0] && !rise) |=> !flag_q[0]); // R9

endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
    import nand_bridge_pkg::*;
#(
    parameter int PULSE_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  xfer_t       req,
    input  logic [7:0]  din,
    output logic        busy,
    output logic        we_n,
    output logic        re_n,
    output logic        doe,
    output logic [7:0]  dout,
    output logic        rd_done,
    output logic [15:0] rd_word
);
    localparam int CW = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_CLKS - 1);

    phase_t      ph;
    logic [CW-1:0] cnt;
    logic        hi;
    xfer_t       cur;
    logic [15:0] gather;
    logic        phase_end;
    logic        last_byte;

    assign phase_end = (cnt == LAST);
    assign last_byte = !cur.wide || hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            hi     <= 1'b0;
            cur    <= '0;
            gather <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        cur    <= req;
                        hi     <= 1'b0;
                        cnt    <= '0;
                        gather <= '0;
                        ph     <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (phase_end) begin
                        cnt <= '0;
                        ph  <= PH_HIGH;
                        if (!cur.wr) begin
                            if (hi) gather[15:8] <= din;
                            else    gather[7:0]  <= din;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (phase_end) begin
                        cnt <= '0;
                        if (last_byte) begin
                            ph <= PH_IDLE;
                        end else begin
                            hi <= 1'b1;
                            ph <= PH_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy    = (ph != PH_IDLE);
    assign we_n    = !(ph == PH_LOW && cur.wr);
    assign re_n    = !(ph == PH_LOW && !cur.wr);
    assign doe     = busy && cur.wr;
    assign dout    = lane_of(cur.wdata, hi);
    assign rd_done = (ph == PH_HIGH) && phase_end && last_byte && !cur.wr;
    assign rd_word = gather;

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> (ph == PH_IDLE)); // R6
    AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_LOW && phase_end) |=> (ph == PH_HIGH)); // R6

endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
    import nand_bridge_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int PULSE_CLKS = 2,
    parameter int IRQ_SRC    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic              host_wide,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              host_wait,
    output logic              host_irq,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_ce_n,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [1:0]        nand_pwr,
    output logic [7:0]        nand_dout,
    output logic              nand_doe,
    input  logic [7:0]        nand_din,
    input  logic              nand_rb
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

    logic        eng_busy, rd_done;
    logic [15:0] rd_word;
    logic        rb_ready, rb_rise;
    logic [7:0]  mode, reg_rd;
    logic        acc, to_data, eng_start, reg_wr;
    xfer_t       req;
    pins_t       pins;

    assign acc       = host_sel && !eng_busy;
    assign to_data   = (host_addr == A_DATA);
    assign eng_start = acc && to_data && (!host_wr || mode[MB_WEQ]);
    assign reg_wr    = acc && host_wr && !to_data;

    always_comb begin
        req.wr    = host_wr;
        req.wide  = host_wide;
        req.wdata = host_wdata;
    end

    nand_rb_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .rb_async (nand_rb),
        .ready    (rb_ready),
        .rise     (rb_rise)
    );

    nand_regs #(
        .ADDR_W  (ADDR_W),
        .IRQ_SRC (IRQ_SRC)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr),
        .addr   (host_addr),
        .wdata  (host_wdata[7:0]),
        .rise   (rb_rise),
        .ready  (rb_ready),
        .mode   (mode),
        .irq    (host_irq),
        .rd_val (reg_rd)
    );

    nand_cycle_engine #(
        .PULSE_CLKS (PULSE_CLKS)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .req     (req),
        .din     (nand_din),
        .busy    (eng_busy),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .doe     (nand_doe),
        .dout    (nand_dout),
        .rd_done (rd_done),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (rd_done) begin
            host_rdata <= rd_word;
        end else if (acc && !host_wr && !to_data) begin
            host_rdata <= {8'h00, reg_rd};
        end
    end

    assign pins      = decode_mode(mode);
    assign nand_cle  = pins.cle;
    assign nand_ale  = pins.ale;
    assign nand_ce_n = pins.ce_n;
    assign nand_pwr  = pins.pwr;
    assign host_wait = eng_busy;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~nand_we_n, ~nand_re_n})); // R6
    AST_WE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !nand_we_n |-> nand_doe); // R4
    AST_CE_STANDBY: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && host_addr == A_MODE && !host_wdata[MB_CE]) |=> nand_ce_n); // R2
    AST_WEQ_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (acc && host_wr && to_data && !mode[MB_WEQ]) |=> (!host_wait && nand_we_n)); // R7

endmodule

// File: tb/nand_bridge_tb.sv
module nand_bridge_tb;
    localparam int CLK_NS = 10;
    localparam int PULSE  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0, host_wr = 1'b0, host_wide = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_wait, host_irq;
    logic        nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_doe;
    logic [1:0]  nand_pwr;
    logic [7:0]  nand_dout;
    logic [7:0]  nand_din;
    logic        nand_rb = 1'b1;

    int errors = 0;
    int checks = 0;

    always #(CLK_NS/2) clk = ~clk;

    nand_bridge #(.ADDR_W(3), .PULSE_CLKS(PULSE), .IRQ_SRC(4)) u_dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
        .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_wait(host_wait), .host_irq(host_irq),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_pwr(nand_pwr),
        .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din),
        .nand_rb(nand_rb)
    );

    function automatic logic [7:0] flash_byte(input int i);
        return 8'((i * 37 + 90) & 255);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model: next byte after each read strobe rise
    int   rd_ptr = 0;
    logic re_prev = 1'b1;
    initial nand_din = flash_byte(0);
    always @(negedge clk) begin
        if (!re_prev && nand_re_n) begin
            rd_ptr++;
            nand_din <= flash_byte(rd_ptr);
        end
        re_prev <= nand_re_n;
    end

    // scoreboard for bytes written to the flash: {cle, ale, byte}
    logic [9:0] exp_q[$];
    logic       we_prev = 1'b1;
    int         we_low = 0;
    int         we_pulses = 0;
    always @(negedge clk) begin
        if (!nand_we_n) we_low++;
        if (!we_prev && nand_we_n) begin
            we_pulses++;
            chk("R6 write strobe low width", we_low, PULSE);
            if (exp_q.size() == 0) begin
                chk("R4 unexpected write byte", 1, 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk("R4 write byte/latch lines", {nand_cle, nand_ale, nand_dout}, e);
            end
            we_low = 0;
        end
        we_prev <= nand_we_n;
    end

    task automatic host_op(input logic wr, input logic wide, input logic [2:0] addr,
                           input logic [15:0] wd, output logic [15:0] rd, output int wcyc);
        @(negedge clk);
        host_sel = 1'b1; host_wr = wr; host_wide = wide; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_sel = 1'b0;
        wcyc = 0;
        while (host_wait) begin
            wcyc++;
            @(negedge clk);
        end
        rd = host_rdata;
    endtask

    task automatic push_write(input logic cle, input logic ale, input logic [15:0] w, input logic wide);
        exp_q.push_back({cle, ale, w[7:0]});
        if (wide) exp_q.push_back({cle, ale, w[15:8]});
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int wc;
        int p;
        int pulses_before;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ce_n", nand_ce_n, 1);
        chk("R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
        chk("R1 latch lines", {nand_cle, nand_ale}, 0);
        chk("R1 power", nand_pwr, 0);
        chk("R1 wait/irq", {host_wait, host_irq}, 0);
        host_op(0, 0, 3'd4, 0, rd, wc);
        chk("R1 mode readback", rd, 16'h0000);

        // R2 command mode
        host_op(1, 0, 3'd4, 16'h0095, rd, wc);
        chk("R2 cmd mode lines", {nand_cle, nand_ale, nand_ce_n, nand_pwr}, {1'b1, 1'b0, 1'b0, 2'b01});
        host_op(0, 0, 3'd4, 0, rd, wc);
        chk("R2 mode readback", rd, 16'h0095);

        // R5/R6 single command byte
        push_write(1, 0, 16'h0090, 0);
        host_op(1, 0, 3'd0, 16'h0090, rd, wc);
        chk("R6 wait length one byte", wc, 2 * PULSE);

        // R2 address mode + single address byte
        host_op(1, 0, 3'd4, 16'h0096, rd, wc);
        chk("R2 addr mode lines", {nand_cle, nand_ale, nand_ce_n}, {1'b0, 1'b1, 1'b0});
        push_write(0, 1, 16'h0000, 0);
        host_op(1, 0, 3'd0, 16'h0000, rd, wc);
        chk("R5 one address cycle wait", wc, 2 * PULSE);

        // R4 wide write in data mode
        host_op(1, 0, 3'd4, 16'h0094, rd, wc);
        push_write(0, 0, 16'hBEEF, 1);
        host_op(1, 1, 3'd0, 16'hBEEF, rd, wc);
        chk("R6 wait length two bytes", wc, 4 * PULSE);
        push_write(0, 0, 16'h1234, 1);
        host_op(1, 1, 3'd0, 16'h1234, rd, wc);

        // R3 wide reads
        p = rd_ptr;
        host_op(0, 1, 3'd0, 0, rd, wc);
        chk("R3 wide read order", rd, {flash_byte(p + 1), flash_byte(p)});
        chk("R3 wide read wait", wc, 4 * PULSE);
        p = rd_ptr;
        host_op(0, 1, 3'd0, 0, rd, wc);
        chk("R3 second wide read", rd, {flash_byte(p + 1), flash_byte(p)});
        // R5 narrow read
        p = rd_ptr;
        host_op(0, 0, 3'd0, 0, rd, wc);
        chk("R5 narrow read", rd, {8'h00, flash_byte(p)});
        chk("R5 narrow read advance", rd_ptr, p + 1);

        // R7 write qualifier clear
        host_op(1, 0, 3'd4, 16'h0014, rd, wc);
        pulses_before = we_pulses;
        host_op(1, 1, 3'd0, 16'hDEAD, rd, wc);
        chk("R7 no wait", wc, 0);
        repeat (3) @(negedge clk);
        chk("R7 no write strobe", we_pulses, pulses_before);

        // R8 status busy
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        host_op(0, 0, 3'd5, 0, rd, wc);
        chk("R8 status busy", rd, 16'h0080);
        nand_rb = 1'b1;
        repeat (5) @(negedge clk);
        host_op(0, 0, 3'd5, 0, rd, wc);
        chk("R8 status ready", rd, 16'h0000);

        // R9 / R10 ready interrupt
        host_op(0, 0, 3'd6, 0, rd, wc);
        chk("R9 flag set once", rd, 16'h0001);
        chk("R10 masked irq", host_irq, 0);
        host_op(1, 0, 3'd7, 16'h0081, rd, wc);
        chk("R10 irq enabled", host_irq, 1);
        host_op(1, 0, 3'd6, 16'h0001, rd, wc);
        chk("R10 irq after clear", host_irq, 0);
        repeat (6) @(negedge clk);
        host_op(0, 0, 3'd6, 0, rd, wc);
        chk("R9 no second set", rd, 16'h0000);
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        nand_rb = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 irq on second edge", host_irq, 1);
        host_op(1, 0, 3'd6, 16'h000F, rd, wc);
        host_op(0, 0, 3'd6, 0, rd, wc);
        chk("R9 clear all", rd, 16'h0000);
        host_op(1, 0, 3'd7, 16'h0000, rd, wc);
        host_op(0, 0, 3'd7, 0, rd, wc);
        chk("R10 mask readback", rd, 16'h0000);

        // R2 power and standby
        host_op(1, 0, 3'd4, 16'h000C, rd, wc);
        chk("R2 power lines", nand_pwr, 2'b11);
        host_op(1, 0, 3'd4, 16'h0000, rd, wc);
        chk("R2 standby ce_n", nand_ce_n, 1);

        repeat (4) @(negedge clk);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule